// File: doc/BRIEF.md
# Per-Channel Preload End-Address Register Guard

This block holds one end-address register for each channel of a cache-preload engine. It also decides whether a coprocessor-style access to the selected channel's register may complete. Every access request arrives with three attributes: its direction, its security world (secure or nonsecure) and its privilege level (privileged or user). The block combines these with two enables. A global nonsecure-enable bit opens the register to the nonsecure world. A user-enable bit for each channel opens that channel to user mode. Each access either completes or is refused with an undefined-instruction flag.

The channel under access is given by a channel-number value that lives outside the block. Software sets it before the access, and the block reads it on the strobe cycle. Only the line-count field of the register can be stored. That field spans bits [N:6], and the top bit N follows the configured L2 size: 14 for 128KB, 15 for 256KB, 16 for 512KB and 17 for 1024KB. With no L2 (0KB) the field is empty, so the engine is given no work. The response arrives one cycle after the strobe. Only one access may be in flight at a time.

Top module: `ple_end_guard`

## Requirements
- R1: A read returns only the bits [N:6] of the stored value, with N = 14, 15, 16, 17 for L2_KB = 128, 256, 512, 1024. All other bits read as zero, and writes to them are dropped. With L2_KB=256, writing 0xFFFFFFFF reads back as 0x0000FFC0. With L2_KB=1024 it reads back as 0x0003FFC0.
- R2: With L2_KB = 0 the register stores nothing and every completed read returns zero.
- R3: A secure privileged access (req_secure=1, req_priv=1) always completes (rsp_undef=0), whatever ns_enable and user_enable hold.
- R4: A nonsecure privileged access completes only when ns_enable=1. Otherwise rsp_undef=1.
- R5: A secure user access completes only when user_enable[chan_sel]=1. Otherwise rsp_undef=1.
- R6: A nonsecure user access completes only when both user_enable[chan_sel]=1 and ns_enable=1. Otherwise rsp_undef=1.
- R7: A refused access leaves every register unchanged and returns rsp_rdata=0.
- R8: chan_sel, sampled on the strobe cycle, picks the register that is read or written and the user-enable bit that is applied. Other channels are not touched.
- R9: rsp_valid pulses for exactly the one cycle after each req_valid strobe, carrying rsp_undef and rsp_rdata. A write returns rsp_rdata=0. A completed write is visible to the very next access.
- R10: After reset every channel register reads as zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ns_enable | input | 1 | Global enable for nonsecure access |
| user_enable | input | NCH | User-mode enable, one bit per channel |
| chan_sel | input | CHW | Channel number for the current access |
| req_valid | input | 1 | Access strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure world, 0 = nonsecure |
| req_priv | input | 1 | 1 = privileged, 0 = user |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_undef | output | 1 | Access refused (undefined-instruction flag) |
| rsp_rdata | output | 32 | Read data, zero on write or refusal |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that secure privileged accesses never fail;
- that nonsecure accesses are refused while ns_enable is low;
- that refused and write responses carry zero data;
- that no read data appears outside the configured field.

Only the bench scenarios can show the rest. That includes whether refused writes really leave the stored value intact, whether user-enable is taken from the selected channel rather than another, and whether channels stay independent. It also covers the exact field width for each L2 size, which the bench checks by reading back through the same port.

// File: rtl/ple_guard_pkg.sv
package ple_guard_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned FIELD_LSB = 6;

    typedef struct packed {
        logic              write;
        logic              secure;
        logic              priv;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic [DATA_W-1:0] rdata;
    } acc_rsp_t;

    typedef enum logic [1:0] {
        CLS_SEC_PRIV  = 2'b11,
        CLS_SEC_USER  = 2'b10,
        CLS_NS_PRIV   = 2'b01,
        CLS_NS_USER   = 2'b00
    } acc_class_e;

    // Highest bit of the line-count field for a given L2 size in KB.
    function automatic int unsigned field_top(input int unsigned l2_kb);
        case (l2_kb)
            128:     return 14;
            256:     return 15;
            512:     return 16;
            1024:    return 17;
            default: return FIELD_LSB;
        endcase
    endfunction

    // Storable bits; empty when no L2 is fitted.
    function automatic logic [DATA_W-1:0] field_mask(input int unsigned l2_kb);
        logic [DATA_W-1:0] m;
        int unsigned top;
        m   = '0;
        top = field_top(l2_kb);
        if (top > FIELD_LSB) begin
            for (int unsigned i = FIELD_LSB; i <= top; i++) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

    function automatic acc_class_e classify(input acc_req_t r);
        return acc_class_e'({r.secure, r.priv});
    endfunction

endpackage

// File: rtl/ple_access_policy.sv
module ple_access_policy
    import ple_guard_pkg::*;
(
    input  acc_req_t req,
    input  logic     ns_enable,
    input  logic     user_en_sel,
    input  logic     chan_ok,
    output logic     grant
);
    acc_class_e cls;
    logic       matrix_ok;

    always_comb begin
        cls = classify(req);
        unique case (cls)
            CLS_SEC_PRIV: matrix_ok = 1'b1;
            CLS_NS_PRIV:  matrix_ok = ns_enable;
            CLS_SEC_USER: matrix_ok = user_en_sel;
            CLS_NS_USER:  matrix_ok = user_en_sel & ns_enable;
            default:      matrix_ok = 1'b0;
        endcase
        grant = matrix_ok & chan_ok;
    end
endmodule

// File: rtl/ple_end_bank.sv
module ple_end_bank
    import ple_guard_pkg::*;
#(
    parameter int unsigned        NCH  = 2,
    parameter int unsigned        CHW  = 1,
    parameter logic [DATA_W-1:0]  MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCH-1:0][DATA_W-1:0] rd_vec
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic [DATA_W-1:0] end_q;
        logic              hit;
        assign hit = wr_en && (32'(wr_ch) == c);
        always_ff @(posedge clk) begin
            if (rst) begin
                end_q <= '0;
            end else if (hit) begin
                end_q <= wdata & MASK;
            end
        end
        assign rd_vec[c] = end_q;
    end
endmodule

// File: rtl/ple_end_guard.sv
module ple_end_guard
    import ple_guard_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned L2_KB = 256,
    parameter int unsigned CHW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ns_enable,
    input  logic [NCH-1:0]    user_enable,
    input  logic [CHW-1:0]    chan_sel,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic              req_priv,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_undef,
    output logic [31:0]       rsp_rdata
);
    localparam logic [DATA_W-1:0] MASK = field_mask(L2_KB);

    acc_req_t                    req;
    acc_rsp_t                    rsp_d, rsp_q;
    logic                        chan_ok;
    logic                        ue_sel;
    logic                        grant;
    logic                        wr_en;
    logic [NCH-1:0][DATA_W-1:0]  rd_vec;

    always_comb begin
        req.write  = req_write;
        req.secure = req_secure;
        req.priv   = req_priv;
        req.wdata  = req_wdata;
        chan_ok    = 32'(chan_sel) < 32'(NCH);
        ue_sel     = chan_ok ? user_enable[chan_sel] : 1'b0;
    end

    ple_access_policy u_policy (
        .req         (req),
        .ns_enable   (ns_enable),
        .user_en_sel (ue_sel),
        .chan_ok     (chan_ok),
        .grant       (grant)
    );

    assign wr_en = req_valid && req.write && grant;

    ple_end_bank #(.NCH(NCH), .CHW(CHW), .MASK(MASK)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_ch  (chan_sel),
        .wdata  (req.wdata),
        .rd_vec (rd_vec)
    );

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.undef = req_valid && !grant;
        rsp_d.rdata = '0;
        if (req_valid && grant && !req.write) begin
            rsp_d.rdata = rd_vec[chan_sel] & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_undef = rsp_q.undef;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/ple_end_guard_chk.sv
module ple_end_guard_chk
    import ple_guard_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned L2_KB = 256,
    parameter int unsigned CHW   = 1
) (
    input logic           clk,
    input logic           rst,
    input logic           ns_enable,
    input logic [NCH-1:0] user_enable,
    input logic [CHW-1:0] chan_sel,
    input logic           req_valid,
    input logic           req_write,
    input logic           req_secure,
    input logic           req_priv,
    input logic           rsp_valid,
    input logic           rsp_undef,
    input logic [31:0]    rsp_rdata
);
    localparam logic [31:0] MASK = field_mask(L2_KB);

    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    assert_write_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));
    assert_secure_priv_ok_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_secure && req_priv && (32'(chan_sel) < 32'(NCH))) |=> !rsp_undef);
    assert_ns_priv_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_secure && req_priv && !ns_enable) |=> rsp_undef);
    assert_ns_user_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_secure && !req_priv && !ns_enable) |=> rsp_undef);
    assert_undef_zero_data_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_undef |-> (rsp_rdata == 32'h0));
    assert_field_only_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_rdata & ~MASK) == 32'h0);
endmodule

bind ple_end_guard ple_end_guard_chk #(.NCH(NCH), .L2_KB(L2_KB), .CHW(CHW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ns_enable   (ns_enable),
    .user_enable (user_enable),
    .chan_sel    (chan_sel),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_secure  (req_secure),
    .req_priv    (req_priv),
    .rsp_valid   (rsp_valid),
    .rsp_undef   (rsp_undef),
    .rsp_rdata   (rsp_rdata)
);

// File: tb/sim_ple_end_guard.sv
`timescale 1ns/100ps
module sim_ple_end_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ns_enable = 1'b0;
    logic [1:0]  user_enable = 2'b00;
    logic [0:0]  chan_sel = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic        req_priv = 1'b0;
    logic [31:0] req_wdata = 32'h0;

    logic        v0, v1, v2, u0f, u1f, u2f;
    logic [31:0] d0, d1, d2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ple_end_guard #(.NCH(2), .L2_KB(256)) u0 (
        .clk(clk), .rst(rst), .ns_enable(ns_enable), .user_enable(user_enable),
        .chan_sel(chan_sel), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_priv(req_priv), .req_wdata(req_wdata),
        .rsp_valid(v0), .rsp_undef(u0f), .rsp_rdata(d0));
    ple_end_guard #(.NCH(2), .L2_KB(0)) u1 (
        .clk(clk), .rst(rst), .ns_enable(ns_enable), .user_enable(user_enable),
        .chan_sel(chan_sel), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_priv(req_priv), .req_wdata(req_wdata),
        .rsp_valid(v1), .rsp_undef(u1f), .rsp_rdata(d1));
    ple_end_guard #(.NCH(2), .L2_KB(1024)) u2 (
        .clk(clk), .rst(rst), .ns_enable(ns_enable), .user_enable(user_enable),
        .chan_sel(chan_sel), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_priv(req_priv), .req_wdata(req_wdata),
        .rsp_valid(v2), .rsp_undef(u2f), .rsp_rdata(d2));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample the response at the next falling edge.
    task automatic access(input logic wr, input logic sec, input logic prv,
                          input logic ch, input logic [31:0] wd,
                          output logic undef, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec; req_priv = prv;
        chan_sel = ch; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 rsp_valid one cycle after strobe", {31'h0, v0}, 32'h1);
        undef = u0f;
        rd = d0;
    endtask

    task automatic test_reset();
        logic un; logic [31:0] rd;
        check("R10 no response pending after reset", {31'h0, v0}, 32'h0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 32'h0, un, rd);
        check("R3 secure priv read with all enables low completes", {31'h0, un}, 32'h0);
        check("R10 ch0 resets to zero", rd, 32'h0);
        access(1'b0, 1'b1, 1'b1, 1'b1, 32'h0, un, rd);
        check("R10 ch1 resets to zero", rd, 32'h0);
    endtask

    task automatic test_mask();
        logic un; logic [31:0] rd;
        access(1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, un, rd);
        check("R3 secure priv write completes", {31'h0, un}, 32'h0);
        check("R9 write returns zero data", rd, 32'h0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 32'h0, un, rd);
        check("R1 256KB field [15:6]", rd, 32'h0000_FFC0);
        check("R1 1024KB field [17:6]", d2, 32'h0003_FFC0);
        check("R2 0KB stores nothing", d1, 32'h0);
        check("R2 0KB read still completes", {31'h0, u1f}, 32'h0);
    endtask

    task automatic test_ns_priv();
        logic un; logic [31:0] rd;
        ns_enable = 1'b0;
        access(1'b1, 1'b0, 1'b1, 1'b0, 32'h1234_5678, un, rd);
        check("R4 ns priv write refused when ns_enable=0", {31'h0, un}, 32'h1);
        access(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, un, rd);
        check("R4 ns priv read refused when ns_enable=0", {31'h0, un}, 32'h1);
        check("R7 refused read gives zero data", rd, 32'h0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 32'h0, un, rd);
        check("R7 refused write left ch0 unchanged", rd, 32'h0000_FFC0);
        ns_enable = 1'b1;
        access(1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0040, un, rd);
        check("R4 ns priv write allowed when ns_enable=1", {31'h0, un}, 32'h0);
        access(1'b0, 1'b0, 1'b1, 1'b0, 32'h0, un, rd);
        check("R4 ns priv read returns written value", rd, 32'h0000_0040);
        ns_enable = 1'b0;
    endtask

    task automatic test_s_user();
        logic un; logic [31:0] rd;
        user_enable = 2'b00;
        access(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, un, rd);
        check("R5 secure user refused with user bit 0", {31'h0, un}, 32'h1);
        user_enable = 2'b01;
        access(1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0100, un, rd);
        check("R8 user bit taken from selected ch1 (off)", {31'h0, un}, 32'h1);
        access(1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_0080, un, rd);
        check("R5 secure user write allowed on ch0", {31'h0, un}, 32'h0);
        access(1'b0, 1'b1, 1'b0, 1'b0, 32'h0, un, rd);
        check("R5 secure user read returns value", rd, 32'h0000_0080);
        access(1'b0, 1'b1, 1'b1, 1'b1, 32'h0, un, rd);
        check("R7 refused ch1 write left ch1 at zero", rd, 32'h0);
    endtask

    task automatic test_ns_user();
        logic un; logic [31:0] rd;
        user_enable = 2'b01; ns_enable = 1'b0;
        access(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, un, rd);
        check("R6 ns user refused with ns_enable=0", {31'h0, un}, 32'h1);
        user_enable = 2'b00; ns_enable = 1'b1;
        access(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, un, rd);
        check("R6 ns user refused with user bit 0", {31'h0, un}, 32'h1);
        user_enable = 2'b01;
        access(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, un, rd);
        check("R6 ns user allowed with both bits", {31'h0, un}, 32'h0);
        check("R6 ns user read data", rd, 32'h0000_0080);
        ns_enable = 1'b0; user_enable = 2'b00;
    endtask

    task automatic test_channels();
        logic un; logic [31:0] rd;
        access(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_FFFF, un, rd);
        access(1'b0, 1'b1, 1'b1, 1'b1, 32'h0, un, rd);
        check("R8 ch1 holds its write", rd, 32'h0000_FFC0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 32'h0, un, rd);
        check("R8 ch0 untouched by ch1 write", rd, 32'h0000_0080);
        @(negedge clk);
        check("R9 rsp_valid drops after one cycle", {31'h0, v0}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_mask();
        test_ns_priv();
        test_s_user();
        test_ns_user();
        test_channels();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule